// File: doc/BRIEF.md
# Base-Index-Offset Address Generator

This block forms the effective addresses of a 64-bit processor that runs every program in one shared address space. For loads, stores and plain address computation it sums three terms: a base, a signed immediate offset of up to 32 bits, and an optional index operand shifted left by a small scale. The base is either a pointer operand or one of six special base registers. Those registers hold the code, constant pool, static data, stack frame, inbound arguments and thread-local storage bases.

For control transfers it either forwards a pointer operand untouched or adds a signed offset to the entry address of the running function. A third form returns that function-relative sum as a pointer and makes no memory access. Some inputs carry a Not-a-Result (NaR) marker. Any result built from a NaR input is tagged NaR and never raises the address-valid strobe. Start-up code loads the special registers through a small register write port. The result appears one cycle after the request.

Top module: `addr_gen_unit`

## Requirements
- R1: After reset `out_valid` and `out_addr_ok` are 0. The code, constant-pool and static-data registers read as address 0 and not NaR. The frame, inbound-argument and thread-local registers read as NaR.
- R2: For operation code 0 (data), `out_addr` = base + sign-extended `in_off` + (`in_idx` << scale), modulo 2^64. When `in_idx_en` is 0 the index term is zero and `in_idx` and `in_idx_nar` have no effect.
- R3: The shift amount is `in_scale` for codes 0 to 4. Codes 5 to 7 shift by 4.
- R4: The base is selected by `in_base_sel`. Code 0 selects `in_ptr`/`in_ptr_nar`. Codes 1 to 6 select code, constant-pool, static-data, frame, inbound-argument and thread-local in that order. Code 7 selects no register and yields NaR.
- R5: A data result is NaR when the selected base is NaR, or when `in_idx_en` is 1 and `in_idx_nar` is 1.
- R6: Operation code 1 (indirect transfer) gives `out_addr` = `in_ptr` and `out_nar` = `in_ptr_nar`. Offset, index and base select have no effect.
- R7: Operation code 2 (relative transfer) gives `in_entry` + sign-extended `in_off` and is never NaR.
- R8: Operation code 3 (relative address compute) gives the same sum as R7. It is never NaR and has `out_access` = 0 and `out_xfer` = 0.
- R9: A write with `cfg_we`=1 and `cfg_sel` in 1..6 (same numbering as R4) updates that register, and requests from the next cycle on see the new value. `cfg_nar` is stored only for selects 4..6; selects 1..3 always store a non-NaR value. Selects 0 and 7 change nothing.
- R10: `out_valid` follows `in_valid` by exactly one cycle. The other outputs belong to the request accepted in that cycle.
- R11: `out_addr_ok` = `out_valid` and not `out_nar`. `out_access` is 1 only for data requests, and `out_xfer` is 1 only for codes 1 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Special register write enable |
| cfg_sel | input | 3 | Special register number (1..6) |
| cfg_wdata | input | 64 | Value to write |
| cfg_nar | input | 1 | Write the register as NaR |
| in_valid | input | 1 | Request valid |
| in_op | input | 2 | 0 data, 1 indirect transfer, 2 relative transfer, 3 relative address compute |
| in_base_sel | input | 3 | Base select (0 operand, 1..6 registers) |
| in_ptr | input | 64 | Pointer operand |
| in_ptr_nar | input | 1 | Pointer operand is NaR |
| in_off | input | 32 | Signed immediate offset |
| in_idx_en | input | 1 | Index term enabled |
| in_idx | input | 64 | Index operand (signed) |
| in_idx_nar | input | 1 | Index operand is NaR |
| in_scale | input | 3 | Index shift amount |
| in_entry | input | 64 | Entry address of current function |
| out_valid | output | 1 | Result valid |
| out_addr | output | 64 | Result address |
| out_nar | output | 1 | Result is NaR |
| out_addr_ok | output | 1 | Valid, non-NaR address strobe |
| out_access | output | 1 | Result addresses memory |
| out_xfer | output | 1 | Result is a control-transfer target |

## Verification
The hardest situation to reach from the ports is a register that changes NaR state and is then read. For example, a frame register moves from NaR to valid and back, or a NaR write is aimed at a register that must refuse it. The outcome then depends on the order of writes and reads. The stimulus places random register writes, with random NaR flags, between random requests on every base select. Directed steps force reads of each register right after reset and right after a refused NaR write. Index NaR with the index disabled, scale codes above 4 and offsets of extreme sign are also driven directly.

// File: rtl/agu_pkg.sv
package agu_pkg;
  localparam int AW    = 64;
  localparam int OFFW  = 32;
  localparam int SELW  = 3;
  localparam int NSPEC = 6;
  localparam int SCW   = 3;
  localparam int MAXSC = 4;

  typedef enum logic [1:0] {
    OP_DATA   = 2'd0,
    OP_JPTR   = 2'd1,
    OP_JREL   = 2'd2,
    OP_LEAREL = 2'd3
  } agu_op_e;

  function automatic logic [AW-1:0] sext_off(input logic [OFFW-1:0] off);
    return {{(AW-OFFW){off[OFFW-1]}}, off};
  endfunction

  function automatic logic [SCW-1:0] clamp_scale(input logic [SCW-1:0] sc);
    return (int'(sc) > MAXSC) ? SCW'(MAXSC) : sc;
  endfunction

  function automatic logic [AW-1:0] scaled_index(input logic en,
                                                 input logic [AW-1:0] idx,
                                                 input logic [SCW-1:0] sc);
    return en ? (idx << clamp_scale(sc)) : '0;
  endfunction

  function automatic logic [AW-1:0] add3(input logic [AW-1:0] a,
                                         input logic [AW-1:0] b,
                                         input logic [AW-1:0] c);
    return a + b + c;
  endfunction
endpackage

// File: rtl/agu_basebank.sv
module agu_basebank
  import agu_pkg::*;
#(
  parameter int W     = AW,
  parameter int N     = NSPEC,
  parameter int SW    = SELW,
  parameter logic [N-1:0] NAR_OK = 6'b111000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [SW-1:0] wr_sel,
  input  logic [W-1:0]  wr_data,
  input  logic          wr_nar,
  input  logic [SW-1:0] rd_sel,
  output logic [W-1:0]  rd_val,
  output logic          rd_nar
);
  logic [W-1:0] val_q [N];
  logic [N-1:0] nar_q;

  for (genvar g = 0; g < N; g++) begin : g_reg
    localparam logic [SW-1:0] MYSEL = SW'(g + 1);
    logic hit;
    assign hit = wr_en && (wr_sel == MYSEL);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        val_q[g] <= '0;
        nar_q[g] <= NAR_OK[g];
      end else if (hit) begin
        val_q[g] <= wr_data;
        nar_q[g] <= wr_nar & NAR_OK[g];
      end
    end
  end

  always_comb begin
    rd_val = '0;
    rd_nar = 1'b1;
    for (int i = 0; i < N; i++) begin
      if (rd_sel == SW'(i + 1)) begin
        rd_val = val_q[i];
        rd_nar = nar_q[i];
      end
    end
  end
endmodule

// File: rtl/agu_datapath.sv
module agu_datapath
  import agu_pkg::*;
(
  input  agu_op_e         op,
  input  logic [SELW-1:0] base_sel,
  input  logic [AW-1:0]   reg_val,
  input  logic            reg_nar,
  input  logic [AW-1:0]   ptr,
  input  logic            ptr_nar,
  input  logic [OFFW-1:0] off,
  input  logic            idx_en,
  input  logic [AW-1:0]   idx,
  input  logic            idx_nar,
  input  logic [SCW-1:0]  scale,
  input  logic [AW-1:0]   entry,
  output logic [AW-1:0]   addr,
  output logic            nar,
  output logic            access,
  output logic            xfer,
  output logic            base_nar
);
  logic [AW-1:0] base;
  logic [AW-1:0] data_sum;
  logic [AW-1:0] rel_sum;

  assign base     = (base_sel == '0) ? ptr : reg_val;
  assign base_nar = (base_sel == '0) ? ptr_nar : reg_nar;
  assign data_sum = add3(base, sext_off(off), scaled_index(idx_en, idx, scale));
  assign rel_sum  = add3(entry, sext_off(off), '0);

  always_comb begin
    unique case (op)
      OP_DATA: begin
        addr = data_sum; nar = base_nar | (idx_en & idx_nar);
        access = 1'b1; xfer = 1'b0;
      end
      OP_JPTR: begin
        addr = ptr; nar = ptr_nar; access = 1'b0; xfer = 1'b1;
      end
      OP_JREL: begin
        addr = rel_sum; nar = 1'b0; access = 1'b0; xfer = 1'b1;
      end
      default: begin
        addr = rel_sum; nar = 1'b0; access = 1'b0; xfer = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/agu_outreg.sv
module agu_outreg
  import agu_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          v_in,
  input  logic [AW-1:0] addr_in,
  input  logic          nar_in,
  input  logic          access_in,
  input  logic          xfer_in,
  output logic          v_out,
  output logic [AW-1:0] addr_out,
  output logic          nar_out,
  output logic          access_out,
  output logic          xfer_out
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_out      <= 1'b0;
      addr_out   <= '0;
      nar_out    <= 1'b0;
      access_out <= 1'b0;
      xfer_out   <= 1'b0;
    end else begin
      v_out <= v_in;
      if (v_in) begin
        addr_out   <= addr_in;
        nar_out    <= nar_in;
        access_out <= access_in;
        xfer_out   <= xfer_in;
      end
    end
  end
endmodule

// File: rtl/addr_gen_unit.sv
module addr_gen_unit
  import agu_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [SELW-1:0] cfg_sel,
  input  logic [AW-1:0]   cfg_wdata,
  input  logic            cfg_nar,
  input  logic            in_valid,
  input  logic [1:0]      in_op,
  input  logic [SELW-1:0] in_base_sel,
  input  logic [AW-1:0]   in_ptr,
  input  logic            in_ptr_nar,
  input  logic [OFFW-1:0] in_off,
  input  logic            in_idx_en,
  input  logic [AW-1:0]   in_idx,
  input  logic            in_idx_nar,
  input  logic [SCW-1:0]  in_scale,
  input  logic [AW-1:0]   in_entry,
  output logic            out_valid,
  output logic [AW-1:0]   out_addr,
  output logic            out_nar,
  output logic            out_addr_ok,
  output logic            out_access,
  output logic            out_xfer
);
  logic [AW-1:0] reg_val;
  logic          reg_nar;
  logic [AW-1:0] calc_addr;
  logic          calc_nar;
  logic          calc_access;
  logic          calc_xfer;
  logic          sel_base_nar;

  agu_basebank i_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_we), .wr_sel(cfg_sel), .wr_data(cfg_wdata), .wr_nar(cfg_nar),
    .rd_sel(in_base_sel), .rd_val(reg_val), .rd_nar(reg_nar)
  );

  agu_datapath i_dp (
    .op(agu_op_e'(in_op)), .base_sel(in_base_sel),
    .reg_val(reg_val), .reg_nar(reg_nar),
    .ptr(in_ptr), .ptr_nar(in_ptr_nar), .off(in_off),
    .idx_en(in_idx_en), .idx(in_idx), .idx_nar(in_idx_nar), .scale(in_scale),
    .entry(in_entry),
    .addr(calc_addr), .nar(calc_nar), .access(calc_access), .xfer(calc_xfer),
    .base_nar(sel_base_nar)
  );

  agu_outreg i_out (
    .clk(clk), .rst_n(rst_n),
    .v_in(in_valid), .addr_in(calc_addr), .nar_in(calc_nar),
    .access_in(calc_access), .xfer_in(calc_xfer),
    .v_out(out_valid), .addr_out(out_addr), .nar_out(out_nar),
    .access_out(out_access), .xfer_out(out_xfer)
  );

  assign out_addr_ok = out_valid & ~out_nar;
endmodule

// File: rtl/agu_checks.sv
module agu_checks (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [1:0]  in_op,
  input logic [63:0] in_ptr,
  input logic        in_ptr_nar,
  input logic        out_valid,
  input logic [63:0] out_addr,
  input logic        out_nar,
  input logic        out_addr_ok,
  input logic        out_access,
  input logic        out_xfer
);
  logic armed;
  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (out_valid == $past(in_valid)));

  p_ok_not_nar_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_addr_ok |-> (out_valid && !out_nar));

  p_kind_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot0({out_access, out_xfer}));

  p_ptr_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(in_valid) && $past(in_op) == 2'd1) |->
      (out_addr == $past(in_ptr) && out_nar == $past(in_ptr_nar) && out_xfer));

  p_rel_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(in_valid) && $past(in_op[1])) |-> (!out_nar && !out_access));

  p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> !out_valid);
endmodule

bind addr_gen_unit agu_checks i_agu_checks (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
  .in_ptr(in_ptr), .in_ptr_nar(in_ptr_nar),
  .out_valid(out_valid), .out_addr(out_addr), .out_nar(out_nar),
  .out_addr_ok(out_addr_ok), .out_access(out_access), .out_xfer(out_xfer)
);

// File: tb/test_addr_gen_unit.sv
`timescale 1ns/1ps
module test_addr_gen_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [2:0]  cfg_sel;
  logic [63:0] cfg_wdata;
  logic        cfg_nar;
  logic        in_valid;
  logic [1:0]  in_op;
  logic [2:0]  in_base_sel;
  logic [63:0] in_ptr;
  logic        in_ptr_nar;
  logic [31:0] in_off;
  logic        in_idx_en;
  logic [63:0] in_idx;
  logic        in_idx_nar;
  logic [2:0]  in_scale;
  logic [63:0] in_entry;
  logic        out_valid;
  logic [63:0] out_addr;
  logic        out_nar;
  logic        out_addr_ok;
  logic        out_access;
  logic        out_xfer;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  logic [63:0] m_val [1:6];
  bit          m_nar [1:6];

  always #5 clk = ~clk;

  addr_gen_unit i_addr_gen_unit (.*);

  function automatic logic [63:0] exp_sum(logic [63:0] b, logic [31:0] o,
                                          bit ie, logic [63:0] ix, logic [2:0] sc);
    logic [63:0] o64 = 64'($signed(o));
    int s = (sc > 3'd4) ? 4 : int'(sc);
    logic [63:0] mul = 64'd1 << s;
    return b + o64 + (ie ? ix * mul : 64'd0);
  endfunction

  task automatic check(string tag, bit ok, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(logic [2:0] s, logic [63:0] d, bit nr);
    cfg_we = 1; cfg_sel = s; cfg_wdata = d; cfg_nar = nr;
    @(negedge clk);
    cfg_we = 0;
    if (s >= 3'd1 && s <= 3'd6) begin
      m_val[s] = d;
      m_nar[s] = (s >= 3'd4) ? nr : 1'b0;
    end
  endtask

  task automatic do_op(string tag, logic [1:0] op, logic [2:0] sel,
                       logic [63:0] p, bit pn, logic [31:0] o, bit ie,
                       logic [63:0] ix, bit inr, logic [2:0] sc, logic [63:0] en);
    logic [63:0] b, ea;
    bit bn, enr, eacc, exf;
    if (sel == 3'd0) begin b = p; bn = pn; end
    else if (sel == 3'd7) begin b = '0; bn = 1; end
    else begin b = m_val[sel]; bn = m_nar[sel]; end
    case (op)
      2'd0: begin ea = exp_sum(b, o, ie, ix, sc); enr = bn || (ie && inr); eacc = 1; exf = 0; end
      2'd1: begin ea = p; enr = pn; eacc = 0; exf = 1; end
      2'd2: begin ea = exp_sum(en, o, 0, '0, 3'd0); enr = 0; eacc = 0; exf = 1; end
      default: begin ea = exp_sum(en, o, 0, '0, 3'd0); enr = 0; eacc = 0; exf = 0; end
    endcase
    in_valid = 1; in_op = op; in_base_sel = sel; in_ptr = p; in_ptr_nar = pn;
    in_off = o; in_idx_en = ie; in_idx = ix; in_idx_nar = inr; in_scale = sc;
    in_entry = en;
    @(negedge clk);
    in_valid = 0;
    check({tag, " valid/R10"}, out_valid === 1'b1, 64'(out_valid), 64'd1);
    check({tag, " nar"}, out_nar === enr, 64'(out_nar), 64'(enr));
    check({tag, " ok/R11"}, out_addr_ok === !enr, 64'(out_addr_ok), 64'(!enr));
    check({tag, " kind/R11"}, out_access === eacc && out_xfer === exf,
          {62'd0, out_access, out_xfer}, {62'd0, eacc, exf});
    if (!enr) check({tag, " addr"}, out_addr === ea, out_addr, ea);
  endtask

  initial begin
    #2ms;
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog expired actual=hang expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 1; i <= 6; i++) begin m_val[i] = '0; m_nar[i] = (i >= 4); end
    rst_n = 0; cfg_we = 0; cfg_sel = 0; cfg_wdata = 0; cfg_nar = 0;
    in_valid = 0; in_op = 0; in_base_sel = 0; in_ptr = 0; in_ptr_nar = 0;
    in_off = 0; in_idx_en = 0; in_idx = 0; in_idx_nar = 0; in_scale = 0; in_entry = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset valid", out_valid === 1'b0, 64'(out_valid), 64'd0);
    check("R1 reset ok", out_addr_ok === 1'b0, 64'(out_addr_ok), 64'd0);
    for (int s = 1; s <= 6; s++)
      do_op("R1 reset reg", 2'd0, 3'(s), '0, 0, 32'd0, 0, '0, 0, 3'd0, '0);

    do_op("R2 wrap", 2'd0, 3'd0, 64'hFFFF_FFFF_FFFF_FFF0, 0, 32'h20, 1, 64'd1, 0, 3'd3, '0);
    do_op("R2 neg off", 2'd0, 3'd0, 64'h1000, 0, 32'h8000_0000, 0, 64'd5, 1, 3'd2, '0);
    do_op("R3 scale7", 2'd0, 3'd0, 64'h100, 0, 32'd0, 1, 64'd3, 0, 3'd7, '0);
    do_op("R3 scale4", 2'd0, 3'd0, 64'h100, 0, 32'd0, 1, -64'sd2, 0, 3'd4, '0);
    do_op("R4 sel7", 2'd0, 3'd7, 64'h55, 0, 32'd1, 0, '0, 0, 3'd0, '0);
    do_op("R5 idx nar", 2'd0, 3'd0, 64'h55, 0, 32'd1, 1, 64'd9, 1, 3'd1, '0);
    do_op("R5 ptr nar", 2'd0, 3'd0, 64'h55, 1, 32'd1, 0, 64'd9, 0, 3'd1, '0);
    do_op("R6 ptr", 2'd1, 3'd4, 64'hDEAD_BEEF_0000_1234, 0, 32'hFFFF, 1, 64'd7, 1, 3'd2, 64'h9);
    do_op("R6 ptr nar", 2'd1, 3'd1, 64'h42, 1, 32'd0, 0, '0, 0, 3'd0, '0);
    do_op("R7 rel", 2'd2, 3'd7, 64'h0, 1, 32'hFFFF_FFFC, 0, '0, 0, 3'd0, 64'h4000);
    do_op("R8 lea", 2'd3, 3'd5, 64'h0, 1, 32'h7FFF_FFFF, 1, 64'd1, 1, 3'd1, 64'h10);

    cfg_write(3'd1, 64'hABCD_0000, 1'b1);
    do_op("R9 nar refused", 2'd0, 3'd1, '0, 0, 32'd4, 0, '0, 0, 3'd0, '0);
    cfg_write(3'd4, 64'h7000, 1'b0);
    do_op("R9 frame set", 2'd0, 3'd4, '0, 0, 32'd8, 1, 64'd2, 0, 3'd2, '0);
    cfg_write(3'd4, 64'h7100, 1'b1);
    do_op("R9 frame nar", 2'd0, 3'd4, '0, 0, 32'd8, 0, '0, 0, 3'd0, '0);
    cfg_write(3'd0, 64'h1, 1'b0);
    cfg_write(3'd7, 64'h1, 1'b0);
    for (int s = 1; s <= 6; s++)
      do_op("R9 sel0/7 ignored", 2'd0, 3'(s), '0, 0, 32'd0, 0, '0, 0, 3'd0, '0);

    for (int k = 0; k < 400; k++) begin
      if (($urandom % 4) == 0)
        cfg_write(3'($urandom % 8), {$urandom, $urandom}, ($urandom % 3) == 0);
      do_op("R2 random", 2'($urandom % 4), 3'($urandom % 8), {$urandom, $urandom},
            ($urandom % 8) == 0, $urandom, 1'($urandom), {$urandom, $urandom},
            ($urandom % 8) == 0, 3'($urandom), {$urandom, $urandom});
      if (($urandom % 5) == 0) begin
        @(negedge clk);
        check("R10 idle", out_valid === 1'b0, 64'(out_valid), 64'd0);
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule